// File: doc/BRIEF.md
# Pin Edge Timestamp Capture

This unit records when level changes occur on four general-purpose pins. A free-running time-of-day value, given as seconds and nanoseconds, comes in on input ports. Two capture channels each watch one pin that software picks at run time. When the watched pin changes level, the channel stores the current time and raises an interrupt cause. Before any pin reaches the edge detector it passes through a two-flop synchronizer. Rising and falling edges both count as events.

Software uses a simple register port to set pin directions, route and enable the channels, mask interrupts, clear causes and read the captured times. A channel keeps its captured time until software reads the seconds word. An event that arrives before that read sets an overflow flag and leaves the stored time unchanged. Setting a pin to output turns off every channel whose source is that pin, so a driven pin can never produce captures.

Top module: `pinevt_capture_top`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is 0 and `irq` is low.
- R2: Register 0 bits [1:0] set the direction of pins 0 and 1. Register 1 bits [1:0] set the direction of pins 2 and 3. A 1 makes the pin an output and drives `pin_oe` for it from the clock edge after the write. Both registers read back what was written.
- R3: Register 2 holds the channel routing. Channel c uses bit 4c as its enable and bits [4c+2:4c+1] as its pin number. When an enabled channel's input pin changes level in either direction, the channel stores `tod_nsec` and `tod_sec` as they stand at the third rising clock edge after the change. It also sets cause bit c of register 4. Channel 0 nanoseconds/seconds read at 5/6, channel 1 at 7/8.
- R4: No capture and no cause occur when the channel is disabled, when only other pins change, or when the selected pin is an output.
- R5: A stored time stays unchanged until the channel's seconds word is read. An event before that read sets overflow bit 2+c of register 4 and keeps the old time. After the read, the next event stores a new time.
- R6: Writing 1 to bits [3:0] of register 4 clears the matching cause or overflow bit. Writing 0 leaves the bit unchanged.
- R7: Register 3 bit c is 1 to let cause c through. `irq` is high exactly when some cause bit is set and its mask bit is 1.
- R8: A write that changes pin p's direction from input to output clears the enable of every channel routed to p. Channels routed to other pins keep their enable.
- R9: Two channels routed to the same pin both capture the same event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_sec | input | 32 | Time-of-day seconds |
| tod_nsec | input | 30 | Time-of-day nanoseconds |
| pin_in | input | 4 | Asynchronous pin levels |
| pin_oe | output | 4 | Pin output enables (1 = output) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed to release a capture) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt line |

## Verification
A hold flag stuck set shows up as overflow bits together with stale times after the seconds word has been read, and the effect is visible on the next event, three cycles after the pin toggles. A hold flag stuck clear shows up as a time that changes when it should not. A routing or gating error sets the wrong cause bit, or sets none, and both `irq` and register 4 show it within four cycles of the edge. An auto-disable fault leaves the enable bit set in register 2, which can be read right after the direction write.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 32;
  localparam int CFG_STRIDE = 4;

  localparam logic [ADDR_W-1:0] A_DIR_LO   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIR_HI   = 4'd1;
  localparam logic [ADDR_W-1:0] A_ROUTE    = 4'd2;
  localparam logic [ADDR_W-1:0] A_MASK     = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAUSE    = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP_BASE = 4'd5;

  // address of the nanosecond word of channel c; seconds word follows it
  function automatic logic [ADDR_W-1:0] cap_ns_addr(input int c);
    return A_CAP_BASE + ADDR_W'(2 * c);
  endfunction
endpackage

// File: rtl/pec_sync_edge.sv
module pec_sync_edge #(
  parameter int N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] pin_is_out,
  output logic [N_PINS-1:0] pin_evt
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pin_in[p];
        s2 <= s1;
        s3 <= s2;
      end
    end
    // any level change of a pin used as input
    assign pin_evt[p] = (s2 ^ s3) & ~pin_is_out[p];
  end
endmodule

// File: rtl/pec_regs.sv
module pec_regs
  import pec_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int N_CH   = 2,
  parameter int SEL_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [N_PINS-1:0]          dir,
  output logic [N_CH-1:0]            ch_en,
  output logic [N_CH-1:0][SEL_W-1:0] ch_sel,
  output logic [N_CH-1:0]            irq_mask
);
  localparam int HALF = N_PINS / 2;

  logic [N_PINS-1:0]          dir_nxt;
  logic [N_CH-1:0]            en_nxt;
  logic [N_CH-1:0][SEL_W-1:0] sel_nxt;
  logic [N_CH-1:0]            mask_nxt;
  logic                       unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  always_comb begin
    dir_nxt  = dir;
    en_nxt   = ch_en;
    sel_nxt  = ch_sel;
    mask_nxt = irq_mask;
    if (wr_en) begin
      if (addr == A_DIR_LO) dir_nxt[HALF-1:0] = wdata[HALF-1:0];
      if (addr == A_DIR_HI) dir_nxt[N_PINS-1:HALF] = wdata[N_PINS-HALF-1:0];
      if (addr == A_MASK) mask_nxt = wdata[N_CH-1:0];
      if (addr == A_ROUTE) begin
        for (int c = 0; c < N_CH; c++) begin
          en_nxt[c]  = wdata[c*CFG_STRIDE];
          sel_nxt[c] = wdata[c*CFG_STRIDE+1 +: SEL_W];
        end
      end
    end
    // a pin newly turned to output drops every channel routed to it
    for (int c = 0; c < N_CH; c++) begin
      if (dir_nxt[sel_nxt[c]] && !dir[sel_nxt[c]]) en_nxt[c] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir      <= '0;
      ch_en    <= '0;
      ch_sel   <= '0;
      irq_mask <= '0;
    end else begin
      dir      <= dir_nxt;
      ch_en    <= en_nxt;
      ch_sel   <= sel_nxt;
      irq_mask <= mask_nxt;
    end
  end

  // previous direction, kept only for the check below
  logic [N_PINS-1:0] dir_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) dir_prev <= '0;
    else        dir_prev <= dir;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R8: an enabled channel never sits on a pin that has just become an output
    a_r8_auto_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[c] && dir[ch_sel[c]]) |-> dir_prev[ch_sel[c]]);
  end
endmodule

// File: rtl/pec_capture_ch.sv
module pec_capture_ch #(
  parameter int N_PINS = 4,
  parameter int SEL_W  = 2,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_PINS-1:0] pin_evt,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [NS_W-1:0]   tod_nsec,
  input  logic              rd_hi,
  input  logic              clr_cause,
  input  logic              clr_ovf,
  output logic [SEC_W-1:0]  cap_sec,
  output logic [NS_W-1:0]   cap_nsec,
  output logic              cause,
  output logic              ovf
);
  logic evt;
  logic held;
  logic can_latch;

  assign evt       = en & pin_evt[sel];
  assign can_latch = !held || rd_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_sec  <= '0;
      cap_nsec <= '0;
      held     <= 1'b0;
    end else if (evt && can_latch) begin
      cap_sec  <= tod_sec;
      cap_nsec <= tod_nsec;
      held     <= 1'b1;
    end else if (rd_hi) begin
      held     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    ovf <= 1'b0;
    else if (evt && !can_latch)    ovf <= 1'b1;
    else if (clr_ovf)              ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cause <= 1'b0;
    else if (evt)       cause <= 1'b1;
    else if (clr_cause) cause <= 1'b0;
  end

  // R5: held time is frozen until the seconds word is read
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !rd_hi) |=> ($stable(cap_sec) && $stable(cap_nsec)));
  // R5: event against a held time reports overflow
  a_r5_ovf_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !rd_hi && evt) |=> ovf);
  // R3: every accepted event leaves the cause set
  a_r3_cause_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cause);
endmodule

// File: rtl/pinevt_capture_top.sv
module pinevt_capture_top
  import pec_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int N_CH   = 2,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [NS_W-1:0]   tod_nsec,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int SEL_W = $clog2(N_PINS);
  localparam int HALF  = N_PINS / 2;

  logic [N_PINS-1:0]          dir;
  logic [N_PINS-1:0]          pin_evt;
  logic [N_CH-1:0]            ch_en;
  logic [N_CH-1:0][SEL_W-1:0] ch_sel;
  logic [N_CH-1:0]            irq_mask;
  logic [N_CH-1:0]            cause;
  logic [N_CH-1:0]            ovf;
  logic [N_CH-1:0][SEC_W-1:0] cap_sec;
  logic [N_CH-1:0][NS_W-1:0]  cap_nsec;
  logic                       cause_wr;

  assign pin_oe   = dir;
  assign cause_wr = reg_wr && (reg_addr == A_CAUSE);

  pec_sync_edge #(.N_PINS(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_is_out(dir), .pin_evt(pin_evt)
  );

  pec_regs #(.N_PINS(N_PINS), .N_CH(N_CH), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dir(dir), .ch_en(ch_en), .ch_sel(ch_sel), .irq_mask(irq_mask)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic rd_hi;
    assign rd_hi = reg_rd && (reg_addr == cap_ns_addr(c) + 4'd1);

    pec_capture_ch #(.N_PINS(N_PINS), .SEL_W(SEL_W), .SEC_W(SEC_W), .NS_W(NS_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(ch_en[c]), .sel(ch_sel[c]), .pin_evt(pin_evt),
      .tod_sec(tod_sec), .tod_nsec(tod_nsec), .rd_hi(rd_hi),
      .clr_cause(cause_wr && reg_wdata[c]), .clr_ovf(cause_wr && reg_wdata[N_CH+c]),
      .cap_sec(cap_sec[c]), .cap_nsec(cap_nsec[c]), .cause(cause[c]), .ovf(ovf[c])
    );

    // R4: a cause only appears for a channel that was enabled
    a_r4_cause_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause[c]) |-> $past(ch_en[c]));
  end

  assign irq = |(cause & irq_mask);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_DIR_LO: reg_rdata[HALF-1:0] = dir[HALF-1:0];
      A_DIR_HI: reg_rdata[N_PINS-HALF-1:0] = dir[N_PINS-1:HALF];
      A_MASK:   reg_rdata[N_CH-1:0] = irq_mask;
      A_CAUSE:  reg_rdata[2*N_CH-1:0] = {ovf, cause};
      A_ROUTE: begin
        for (int c = 0; c < N_CH; c++) begin
          reg_rdata[c*CFG_STRIDE] = ch_en[c];
          reg_rdata[c*CFG_STRIDE+1 +: SEL_W] = ch_sel[c];
        end
      end
      default: begin
        for (int c = 0; c < N_CH; c++) begin
          if (reg_addr == cap_ns_addr(c))        reg_rdata = DATA_W'(cap_nsec[c]);
          if (reg_addr == cap_ns_addr(c) + 4'd1) reg_rdata = DATA_W'(cap_sec[c]);
        end
      end
    endcase
  end
endmodule

// File: tb/pinevt_capture_top_tb.sv
module pinevt_capture_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tod_sec = '0;
  logic [29:0] tod_nsec = '0;
  logic [3:0]  pins = '0;
  logic [3:0]  pin_oe;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pinevt_capture_top u_dut (
    .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_nsec(tod_nsec),
    .pin_in(pins), .pin_oe(pin_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic toggle(logic [3:0] m);
    @(negedge clk); pins = pins ^ m;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] route(bit e0, int s0, bit e1, int s1);
    return {24'd0, 1'b0, 2'(s1), e1, 1'b0, 2'(s0), e0};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m_sec [2];
    logic [29:0] m_ns [2];
    bit m_held [2], m_known [2];
    logic [1:0] m_cause, m_ovf;
    int sel [2];
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d); chk("R1 reg", d, 32'd0);
    end
    chk("R1 pin_oe", {28'd0, pin_oe}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 direction registers
    wr(4'd0, 32'h2); wr(4'd1, 32'h1);
    chk("R2 pin_oe", {28'd0, pin_oe}, 32'h6);
    rd(4'd0, d); chk("R2 dir_lo", d, 32'h2);
    rd(4'd1, d); chk("R2 dir_hi", d, 32'h1);
    wr(4'd0, 0); wr(4'd1, 0);

    // R3 capture latency: time counts up each cycle after the toggle
    wr(4'd2, route(1, 2, 0, 0));
    @(negedge clk); tod_sec = 32'h10; tod_nsec = 30'd100; pins = pins ^ 4'h4;
    repeat (4) begin @(negedge clk); tod_nsec = tod_nsec + 1; end
    rd(4'd5, d); chk("R3 nsec at third edge", d, 32'd102);
    rd(4'd6, d); chk("R3 sec", d, 32'h10);
    rd(4'd4, d); chk("R3 cause", d, 32'h1);
    chk("R7 masked irq", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'h1);
    chk("R7 unmasked irq", {31'd0, irq}, 32'd1);
    wr(4'd4, 32'h0);
    rd(4'd4, d); chk("R6 write zero keeps", d, 32'h1);
    wr(4'd4, 32'h1);
    rd(4'd4, d); chk("R6 write one clears", d, 32'h0);
    chk("R6 irq drops", {31'd0, irq}, 32'd0);

    // R5 hold and overflow
    tod_nsec = 30'd200; toggle(4'h4);
    tod_nsec = 30'd300; toggle(4'h4);
    rd(4'd4, d); chk("R5 overflow flag", d, 32'h5);
    rd(4'd5, d); chk("R5 value kept", d, 32'd200);
    rd(4'd6, d);
    wr(4'd4, 32'hF);
    tod_nsec = 30'd400; toggle(4'h4);
    rd(4'd5, d); chk("R5 recapture after release", d, 32'd400);
    rd(4'd6, d);
    wr(4'd4, 32'hF);

    // R4 gating
    wr(4'd2, route(0, 0, 0, 0)); toggle(4'h1);
    rd(4'd4, d); chk("R4 disabled channel", d, 32'h0);
    wr(4'd2, route(1, 0, 0, 0)); toggle(4'h2);
    rd(4'd4, d); chk("R4 other pin", d, 32'h0);
    wr(4'd0, 32'h1);
    wr(4'd2, route(1, 0, 0, 0));
    chk("R2 pin0 output", {28'd0, pin_oe}, 32'h1);
    toggle(4'h1);
    rd(4'd4, d); chk("R4 output pin", d, 32'h0);
    wr(4'd0, 32'h0);

    // R8 auto-disable
    wr(4'd2, route(1, 2, 1, 3));
    wr(4'd1, 32'h1);
    rd(4'd2, d); chk("R8 route after pin2 output", d, route(0, 2, 1, 3));
    wr(4'd1, 32'h0);

    // R9 shared pin
    wr(4'd2, route(1, 0, 1, 0));
    tod_nsec = 30'd500; toggle(4'h1);
    rd(4'd5, d); chk("R9 ch0", d, 32'd500);
    rd(4'd7, d); chk("R9 ch1", d, 32'd500);
    rd(4'd4, d); chk("R9 both causes", d, 32'h3);
    rd(4'd6, d); rd(4'd8, d);
    wr(4'd4, 32'hF);

    // random phase
    m_held = '{0, 0}; m_known = '{0, 0};
    for (int it = 0; it < 40; it++) begin
      logic [3:0] tg;
      logic [1:0] msk;
      int reps;
      m_cause = '0; m_ovf = '0;
      sel[0] = int'($urandom % 4); sel[1] = int'($urandom % 4);
      msk = 2'($urandom);
      wr(4'd2, route(1, sel[0], 1, sel[1]));
      wr(4'd3, {30'd0, msk});
      reps = 1 + int'($urandom % 2);
      for (int r = 0; r < reps; r++) begin
        tod_sec = $urandom; tod_nsec = 30'($urandom % 1000000000);
        tg = 4'($urandom);
        toggle(tg);
        for (int c = 0; c < 2; c++) begin
          if (tg[sel[c]]) begin
            if (m_held[c]) m_ovf[c] = 1'b1;
            else begin
              m_sec[c] = tod_sec; m_ns[c] = tod_nsec;
              m_held[c] = 1; m_known[c] = 1;
            end
            m_cause[c] = 1'b1;
          end
        end
      end
      chk("R7 random irq", {31'd0, irq}, {31'd0, |(m_cause & msk)});
      rd(4'd4, d); chk("R6 random status", d, {28'd0, m_ovf, m_cause});
      if ($urandom % 2 == 0) begin
        for (int c = 0; c < 2; c++) begin
          rd(4'(5 + 2 * c), d);
          if (m_known[c]) chk("R3 random nsec", d, {2'd0, m_ns[c]});
          rd(4'(6 + 2 * c), d);
          if (m_known[c]) chk("R5 random sec", d, m_sec[c]);
          m_held[c] = 0;
        end
      end
      wr(4'd4, 32'hF);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule